// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Byte

This block is the execution stage of a small eight-bit processor core. Each cycle it takes an operation code, a first operand from the register file, and a second operand. The second operand is either another register value or an immediate from the instruction word. It also takes the current status byte. At the next rising clock edge it presents the result byte and the new status byte. The surrounding core decodes instructions, owns the register file, and writes the new status byte back so that it can feed the next operation.

Operations fall into three groups. The arithmetic group holds addition and subtraction, each with and without the incoming carry. The logical group holds AND, OR, exclusive OR and ones' complement. The bit-level group sets, clears and tests single bits of the first operand, moves bits between that operand and the bit-copy flag, and sets or clears individual status bits. Each group updates the flags by its own rule. The interrupt-enable and bit-copy flags only change when an operation names them.

Top module: `alu8_flags`

## Requirements
- R1: `result` and `status_out` are registered. At a rising edge where `rst_n` is low, both become 0x00. At any other rising edge, they take the value computed from the inputs present at that edge.
- R2: The second operand B equals `imm` when `use_imm` is 1, and `reg_b` when it is 0. The first operand A is always `reg_a`.
- R3: Status bit positions are 7 interrupt enable (I), 6 bit copy (T), 5 half carry (H), 4 sign (S), 3 overflow (V), 2 negative (N), 1 zero (Z), 0 carry (C). After any arithmetic or logical operation, S = N xor V.
- R4: Opcode 0 gives A+B and opcode 1 gives A+B+C_in. C is the carry out of bit 7. H is the carry out of bit 3. V is set when the result overflows as a signed two's-complement value.
- R5: Opcode 2 gives A-B and opcode 3 gives A-B-C_in. C is set when a borrow is needed (unsigned A < B + borrow-in). H is set when bit 4 must lend to the low nibble. V is set on signed overflow.
- R6: After an arithmetic or logical operation, N equals result bit 7 and Z is 1 exactly when the result is zero.
- R7: Opcodes 4 (AND), 5 (OR), 6 (XOR) and 7 (ones' complement of A) clear V. They leave C and H at their incoming values.
- R8: Opcode 8 returns A with bit `bit_sel` set. Opcode 9 returns A with that bit cleared. Both leave the status byte unchanged.
- R9: Opcode 10 returns A unchanged. It sets Z to the inverse of A bit `bit_sel` and leaves every other status bit unchanged.
- R10: Opcode 11 copies A bit `bit_sel` into T and returns A. Opcode 12 returns A with bit `bit_sel` replaced by the incoming T, and leaves the status byte unchanged.
- R11: Opcode 13 sets status bit `bit_sel` and opcode 14 clears it. Both return A. Opcode 15 returns A and leaves the status byte unchanged.
- R12: I and T keep their incoming values for every opcode except 11 (T), 13 and 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Selects the immediate as operand B |
| reg_a | input | 8 | First register operand |
| reg_b | input | 8 | Second register operand |
| imm | input | 8 | Immediate operand |
| bit_sel | input | 3 | Bit index for bit-level operations |
| status_in | input | 8 | Incoming status byte |
| result | output | 8 | Registered result byte |
| status_out | output | 8 | Registered updated status byte |

## Verification
The only state is the pair of output registers, so any fault becomes visible one edge after the operands are applied. It shows as a wrong result byte or as a single wrong flag. The risky faults are a carry or borrow taken from the wrong bit, an inverted borrow sense, and a flag that leaks through an operation that should preserve it. The directed cases aim at each of these: nibble and byte boundaries, signed overflow on both ends, and incoming flags set to patterns that would expose an unwanted change. A model sweep then compares all eight flags across every opcode.

// File: rtl/alu8_pkg.sv
// Shared opcode encoding and status bit positions for the eight-bit ALU.
// Assumes a fixed eight-bit status byte; positions are decoded by the core.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC  = 4'd3,
        OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_COM  = 4'd7,
        OP_BSET = 4'd8,  OP_BCLR = 4'd9,  OP_BTST = 4'd10, OP_BST  = 4'd11,
        OP_BLD  = 4'd12, OP_SEF  = 4'd13, OP_CLF  = 4'd14, OP_NOP  = 4'd15
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;
endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor with carry, half carry and signed overflow outputs.
// Assumes subtraction is done as A + ~B + ~borrow_in; c_out and h_out
// report borrows (not carries) when sub is high.
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cy_in,
    input  logic          sub,
    output logic [DW-1:0] r,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    localparam int NIB = DW / 2;

    logic [DW-1:0] b_eff;
    logic          cin_eff;
    logic [DW:0]   full_sum;
    logic [NIB:0]  low_sum;

    // Form the effective operand and carry, then add full width and low nibble.
    always_comb begin
        b_eff    = sub ? ~b : b;
        cin_eff  = sub ? ~cy_in : cy_in;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
        low_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin_eff};
        r        = full_sum[DW-1:0];
        c_out    = sub ? ~full_sum[DW] : full_sum[DW];
        h_out    = sub ? ~low_sum[NIB] : low_sum[NIB];
        v_out    = (a[DW-1] == b_eff[DW-1]) && (r[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise logic unit: AND, OR, XOR and ones' complement of operand A.
// Assumes the two low opcode bits pick the function.
module alu8_logic #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    fn,
    output logic [DW-1:0] r
);
    // Select the bitwise function.
    always_comb begin
        unique case (fn)
            2'd0:    r = a & b;
            2'd1:    r = a | b;
            2'd2:    r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/alu8_bitops.sv
// Single-bit manipulation of operand A and of the status byte.
// Assumes bit_sel indexes both A and the status byte (both DW bits wide).
module alu8_bitops #(
    parameter int DW = 8,
    parameter int SW = $clog2(DW)
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [SW-1:0] bit_sel,
    input  logic [7:0]    st_in,
    output logic [DW-1:0] r,
    output logic [7:0]    st_out
);
    import alu8_pkg::*;

    logic [DW-1:0] mask;
    logic [7:0]    smask;
    logic          a_bit;

    // Decode the bit masks and the selected operand bit.
    always_comb begin
        mask  = {{(DW-1){1'b0}}, 1'b1} << bit_sel;
        smask = 8'd1 << bit_sel;
        a_bit = |(a & mask);
    end

    // Apply the bit-level operation to the operand and to the status byte.
    always_comb begin
        r      = a;
        st_out = st_in;
        unique case (op)
            OP_BSET: r = a | mask;
            OP_BCLR: r = a & ~mask;
            OP_BTST: st_out[FL_Z] = ~a_bit;
            OP_BST:  st_out[FL_T] = a_bit;
            OP_BLD:  r = st_in[FL_T] ? (a | mask) : (a & ~mask);
            OP_SEF:  st_out = st_in | smask;
            OP_CLF:  st_out = st_in & ~smask;
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
// Top of the eight-bit ALU: operand select, unit dispatch, flag merge and
// output registers. Assumes a synchronous active-low reset and that the
// caller feeds status_out back as status_in for chained operations.
module alu8_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] op_sel,
    input  logic       use_imm,
    input  logic [7:0] reg_a,
    input  logic [7:0] reg_b,
    input  logic [7:0] imm,
    input  logic [2:0] bit_sel,
    input  logic [7:0] status_in,
    output logic [7:0] result,
    output logic [7:0] status_out
);
    import alu8_pkg::*;

    localparam int DW = 8;

    logic [DW-1:0] opnd_b;
    logic [DW-1:0] as_r, lg_r, bt_r;
    logic          as_c, as_h, as_v;
    logic [7:0]    bt_st;
    logic          is_arith, is_logic;
    logic [DW-1:0] nxt_r;
    logic [7:0]    nxt_st;

    // Choose the second operand and classify the opcode.
    always_comb begin
        opnd_b   = use_imm ? imm : reg_b;
        is_arith = (op_sel[3:2] == 2'b00);
        is_logic = (op_sel[3:2] == 2'b01);
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a     (reg_a),
        .b     (opnd_b),
        .cy_in (op_sel[0] & status_in[FL_C]),
        .sub   (op_sel[1]),
        .r     (as_r),
        .c_out (as_c),
        .h_out (as_h),
        .v_out (as_v)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .a  (reg_a),
        .b  (opnd_b),
        .fn (op_sel[1:0]),
        .r  (lg_r)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op      (op_sel),
        .a       (reg_a),
        .bit_sel (bit_sel),
        .st_in   (status_in),
        .r       (bt_r),
        .st_out  (bt_st)
    );

    // Merge the unit results and apply the per-class flag rules.
    always_comb begin
        nxt_r  = bt_r;
        nxt_st = bt_st;
        if (is_arith) begin
            nxt_r         = as_r;
            nxt_st        = status_in;
            nxt_st[FL_C]  = as_c;
            nxt_st[FL_H]  = as_h;
            nxt_st[FL_V]  = as_v;
        end else if (is_logic) begin
            nxt_r         = lg_r;
            nxt_st        = status_in;
            nxt_st[FL_V]  = 1'b0;
        end
        if (is_arith || is_logic) begin
            nxt_st[FL_N] = nxt_r[DW-1];
            nxt_st[FL_Z] = (nxt_r == '0);
            nxt_st[FL_S] = nxt_r[DW-1] ^ nxt_st[FL_V];
        end
    end

    // Register the result and status, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            status_out <= '0;
        end else begin
            result     <= nxt_r;
            status_out <= nxt_st;
        end
    end

    // R1: outputs are zero after a reset edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (result == 8'h00 && status_out == 8'h00));

    // R3: sign flag tracks N xor V after arithmetic and logical operations.
    a_r3_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel[3]) == 1'b0) |->
        (status_out[FL_S] == (status_out[FL_N] ^ status_out[FL_V])));

    // R6: zero flag matches the registered result.
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel[3]) == 1'b0) |->
        (status_out[FL_Z] == (result == 8'h00)));

    // R7: logical ops clear V and keep the incoming carry and half carry.
    a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel[3:2]) == 2'b01) |->
        (!status_out[FL_V] && status_out[FL_C] == $past(status_in[FL_C])
         && status_out[FL_H] == $past(status_in[FL_H])));

    // R8: bit set and clear touch at most one result bit and no flag.
    a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_sel) == 4'd8 || $past(op_sel) == 4'd9)) |->
        ($countones(result ^ $past(reg_a)) <= 1 && status_out == $past(status_in)));

    // R12: interrupt enable only moves under the status set/clear opcodes.
    a_r12_i_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) != 4'd13 && $past(op_sel) != 4'd14) |->
        (status_out[FL_I] == $past(status_in[FL_I])));
endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic       use_imm = 1'b0;
    logic [7:0] reg_a = '0, reg_b = '0, imm = '0, status_in = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result, status_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu8_flags u_alu8_flags (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .bit_sel(bit_sel),
        .status_in(status_in), .result(result), .status_out(status_out)
    );

    // Behavioural model built from the requirements: returns {result, status}.
    function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [2:0] bs,
                                          input logic [7:0] s);
        logic [7:0] r = a;
        logic [7:0] st = s;
        int ci, full, low, sgn;
        ci = (op == 4'd1 || op == 4'd3) ? int'(s[0]) : 0;
        case (op)
            4'd0, 4'd1: begin
                full = int'(a) + int'(b) + ci;
                low  = int'(a[3:0]) + int'(b[3:0]) + ci;
                sgn  = int'($signed(a)) + int'($signed(b)) + ci;
                r = full[7:0];
                st[0] = full > 255; st[5] = low > 15; st[3] = (sgn > 127 || sgn < -128);
            end
            4'd2, 4'd3: begin
                full = int'(a) - int'(b) - ci;
                low  = int'(a[3:0]) - int'(b[3:0]) - ci;
                sgn  = int'($signed(a)) - int'($signed(b)) - ci;
                r = full[7:0];
                st[0] = full < 0; st[5] = low < 0; st[3] = (sgn > 127 || sgn < -128);
            end
            4'd4: begin r = a & b; st[3] = 1'b0; end
            4'd5: begin r = a | b; st[3] = 1'b0; end
            4'd6: begin r = a ^ b; st[3] = 1'b0; end
            4'd7: begin r = ~a;    st[3] = 1'b0; end
            4'd8:  r[bs] = 1'b1;
            4'd9:  r[bs] = 1'b0;
            4'd10: st[1] = ~a[bs];
            4'd11: st[6] = a[bs];
            4'd12: r[bs] = s[6];
            4'd13: st[bs] = 1'b1;
            4'd14: st[bs] = 1'b0;
            default: ;
        endcase
        if (op < 4'd8) begin
            st[2] = r[7]; st[1] = (r == 8'h00); st[4] = r[7] ^ st[3];
        end
        return {r, st};
    endfunction

    task automatic check8(input string req, input string what, input logic [7:0] act,
                          input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Apply one operation, let it register, and compare with the model.
    task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] im, input logic ui,
                          input logic [2:0] bs, input logic [7:0] s,
                          output logic [7:0] r_o, output logic [7:0] s_o);
        logic [15:0] exp;
        @(negedge clk);
        op_sel = op; reg_a = a; reg_b = b; imm = im; use_imm = ui; bit_sel = bs;
        status_in = s;
        exp = model(op, a, ui ? im : b, bs, s);
        @(posedge clk); #1;
        r_o = result; s_o = status_out;
        check8(req, "result", result, exp[15:8]);
        check8(req, "status", status_out, exp[7:0]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; op_sel = 4'd13; reg_a = 8'hA5; status_in = 8'h7F; bit_sel = 3'd7;
        @(posedge clk); #1;
        check8("R1", "reset result", result, 8'h00);
        check8("R1", "reset status", status_out, 8'h00);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_add();
        logic [7:0] r, s;
        run_op("R4", 4'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 3'd0, 8'h00, r, s);
        check8("R4", "7F+01 result", r, 8'h80);
        check8("R4", "7F+01 status H,S clear? V,N", s, 8'h2C);
        run_op("R4", 4'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 3'd0, 8'hC0, r, s);
        check8("R4", "FF+01 status", s, 8'hE3);
        run_op("R4", 4'd1, 8'h10, 8'h20, 8'h00, 1'b0, 3'd0, 8'h01, r, s);
        check8("R4", "ADC carry in", r, 8'h31);
        run_op("R4", 4'd0, 8'h80, 8'h80, 8'h00, 1'b0, 3'd0, 8'h00, r, s);
    endtask

    task automatic t_sub();
        logic [7:0] r, s;
        run_op("R5", 4'd2, 8'h00, 8'h01, 8'h00, 1'b0, 3'd0, 8'h00, r, s);
        check8("R5", "00-01 status", s, 8'h35);
        run_op("R5", 4'd2, 8'h80, 8'h01, 8'h00, 1'b0, 3'd0, 8'h00, r, s);
        check8("R5", "80-01 status", s, 8'h38);
        run_op("R5", 4'd3, 8'h05, 8'h05, 8'h00, 1'b0, 3'd0, 8'h01, r, s);
        check8("R5", "SBC borrow in", r, 8'hFF);
        run_op("R6", 4'd2, 8'h42, 8'h42, 8'h00, 1'b0, 3'd0, 8'h00, r, s);
        check8("R6", "equal sub zero", s, 8'h02);
    endtask

    task automatic t_imm();
        logic [7:0] r, s;
        run_op("R2", 4'd0, 8'h10, 8'h01, 8'h22, 1'b1, 3'd0, 8'h00, r, s);
        check8("R2", "immediate used", r, 8'h32);
        run_op("R2", 4'd0, 8'h10, 8'h01, 8'h22, 1'b0, 3'd0, 8'h00, r, s);
        check8("R2", "register used", r, 8'h11);
    endtask

    task automatic t_logic();
        logic [7:0] r, s;
        run_op("R7", 4'd4, 8'hF0, 8'h0F, 8'h00, 1'b0, 3'd0, 8'h29, r, s);
        check8("R7", "AND keeps C,H clears V", s, 8'h23);
        run_op("R7", 4'd5, 8'h80, 8'h01, 8'h00, 1'b0, 3'd0, 8'h08, r, s);
        run_op("R7", 4'd6, 8'hAA, 8'hAA, 8'h00, 1'b0, 3'd0, 8'hC0, r, s);
        run_op("R7", 4'd7, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h01, r, s);
        check8("R7", "COM result", r, 8'hFF);
    endtask

    task automatic t_bits();
        logic [7:0] r, s;
        run_op("R8", 4'd8, 8'h00, 8'h00, 8'h00, 1'b0, 3'd5, 8'h5A, r, s);
        check8("R8", "BSET result", r, 8'h20);
        run_op("R8", 4'd9, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd0, 8'hA5, r, s);
        check8("R8", "BCLR result", r, 8'hFE);
        run_op("R9", 4'd10, 8'h08, 8'h00, 8'h00, 1'b0, 3'd3, 8'h02, r, s);
        check8("R9", "BTST set bit Z clear", s, 8'h00);
        run_op("R9", 4'd10, 8'h08, 8'h00, 8'h00, 1'b0, 3'd2, 8'hFD, r, s);
        run_op("R10", 4'd11, 8'h80, 8'h00, 8'h00, 1'b0, 3'd7, 8'h00, r, s);
        check8("R10", "BST to T", s, 8'h40);
        run_op("R10", 4'd12, 8'h00, 8'h00, 8'h00, 1'b0, 3'd4, 8'h40, r, s);
        check8("R10", "BLD from T", r, 8'h10);
        run_op("R10", 4'd12, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd4, 8'hBF, r, s);
    endtask

    task automatic t_flagops();
        logic [7:0] r, s;
        run_op("R11", 4'd13, 8'h33, 8'h00, 8'h00, 1'b0, 3'd7, 8'h00, r, s);
        check8("R11", "SEF I", s, 8'h80);
        run_op("R11", 4'd14, 8'h33, 8'h00, 8'h00, 1'b0, 3'd6, 8'hFF, r, s);
        check8("R11", "CLF T", s, 8'hBF);
        run_op("R11", 4'd15, 8'h5C, 8'h11, 8'h00, 1'b0, 3'd1, 8'h96, r, s);
        check8("R12", "NOP keeps I,T", s, 8'h96);
    endtask

    // Model sweep over every opcode with varied operands and status (R3, R12).
    task automatic t_sweep();
        logic [7:0] r, s;
        for (int i = 0; i < 1024; i++) begin
            run_op("R3/R12 sweep", 4'(i % 16), 8'($urandom), 8'($urandom), 8'($urandom),
                   1'($urandom), 3'($urandom), 8'($urandom), r, s);
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_imm();
        t_logic();
        t_bits();
        t_flagops();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule